// File: doc/BRIEF.md
# Mode Strap and Interrupt Pin Controller

This block owns a small group of shared external pins that have two jobs. While the chip is held in reset, the pins are read as a static operating-mode strap. The strap value is latched into a mode register on the first clock edge after reset is released. From then on, each pin acts as an active-low external interrupt request.

Every pin passes through its own synchronizer chain into the core clock domain. A per-pin configuration bit selects how the pin is read. In level mode, the request follows the synchronized pin for as long as it is low. In edge mode, a high-to-low transition sets a sticky pending flag, and the flag stays set until the core clears it. Each request has an enable bit. A disabled request still records its pending state but does not drive its request output.

A combined wake output is raised whenever any enabled request is active, so that the core can leave a wait state. Priority between requests, vectoring, and any use of the mode value are left to the surrounding logic.

Top module: `strap_irq_ctrl`

## Requirements
- R1: While `rst_n` is low (synchronous, active low), `mode_q`, `pending`, `irq_req` and `wake` are all zero, whatever the pin levels are.
- R2: On the first rising clock edge at which `rst_n` is sampled high, `mode_q` loads the pin levels, with bit i taken from `pin_n[i]`. The pins must have been stable for at least three cycles before that edge. After that edge, `mode_q` does not change until the next reset.
- R3: Pins held low across the release of reset never set an edge-mode pending bit.
- R4: In level mode (`edge_sel[i]`=0), `pending[i]` is 1 exactly while the synchronized pin is low. A pin change shows on `pending[i]` after the second rising edge that follows it.
- R5: In edge mode (`edge_sel[i]`=1), a high-to-low pin transition sets `pending[i]` after the third rising edge that follows it. The bit then stays set after the pin returns high.
- R6: When `clr_pend[i]` is high at a rising edge, an edge-mode `pending[i]` is cleared. If a new falling edge is detected in that same cycle, the set wins. In level mode, `clr_pend[i]` has no effect on `pending[i]`.
- R7: `irq_req[i]` equals `pending[i] & irq_en[i]`. A disabled pin still shows its `pending[i]` bit.
- R8: `wake` is high exactly when at least one `irq_req` bit is high.
- R9: In edge mode, a low-to-high pin transition does not set `pending`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset; the strap is latched when it goes high |
| pin_n | input | NPINS | Shared strap / interrupt pins, asynchronous, active low as requests |
| edge_sel | input | NPINS | Per pin: 1 = falling-edge detection, 0 = low-level detection |
| irq_en | input | NPINS | Per pin request enable |
| clr_pend | input | NPINS | Per pin clear of the edge pending flag |
| mode_q | output | NPINS | Latched operating-mode strap |
| pending | output | NPINS | Per pin pending state |
| irq_req | output | NPINS | Per pin enabled request |
| wake | output | 1 | Any enabled request active |

## Verification
The strap is latched twice, with two different pin patterns, which shows that the latched value comes from the pins and not from a fixed value. Low pins are held across the release of reset in edge mode, to separate true transitions from strap levels. In edge mode the bench drives a falling edge, a rising edge, a clear alone, and a clear that collides with a new edge; these four cases separate a sticky flag from one that simply follows the pin. In level mode the pins are toggled and sampled one cycle before and on the cycle the change arrives, which pins down the synchronizer latency. Masked and unmasked cases separate the pending flags from the request outputs.

// File: rtl/strap_irq_ctrl.sv
module strap_irq_ctrl #(
  parameter int NPINS       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_n,
  input  logic [NPINS-1:0] edge_sel,
  input  logic [NPINS-1:0] irq_en,
  input  logic [NPINS-1:0] clr_pend,
  output logic [NPINS-1:0] mode_q,
  output logic [NPINS-1:0] pending,
  output logic [NPINS-1:0] irq_req,
  output logic             wake
);
  localparam int CHAIN = SYNC_STAGES + 1;

  logic [CHAIN-1:0][NPINS-1:0] chain;
  logic [NPINS-1:0]            cur, prev, fall, pend_q;
  logic                        in_rst;

  always_ff @(posedge clk) begin
    chain[0] <= pin_n;
    for (int k = 1; k < CHAIN; k++) chain[k] <= chain[k-1];
  end

  assign cur  = chain[SYNC_STAGES-1];
  assign prev = chain[SYNC_STAGES];
  assign fall = prev & ~cur & {NPINS{~in_rst}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_rst <= 1'b1;
      mode_q <= '0;
    end else begin
      in_rst <= 1'b0;
      if (in_rst) mode_q <= cur;
    end
  end

  for (genvar gi = 0; gi < NPINS; gi++) begin : g_pin
    always_ff @(posedge clk) begin
      if (!rst_n)                           pend_q[gi] <= 1'b0;
      else if (edge_sel[gi] && fall[gi])    pend_q[gi] <= 1'b1;
      else if (clr_pend[gi])                pend_q[gi] <= 1'b0;
    end
    assign pending[gi] = edge_sel[gi] ? pend_q[gi] : (~cur[gi] & ~in_rst);
  end

  assign irq_req = pending & irq_en;
  assign wake    = |irq_req;
endmodule

module strap_irq_ctrl_chk #(
  parameter int NPINS = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPINS-1:0] edge_sel,
  input logic [NPINS-1:0] irq_en,
  input logic [NPINS-1:0] clr_pend,
  input logic [NPINS-1:0] mode_q,
  input logic [NPINS-1:0] pending,
  input logic [NPINS-1:0] irq_req
);
  p_quiet_at_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pending == '0 && irq_req == '0 && mode_q == '0));

  p_mode_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(rst_n, 2)) |-> $stable(mode_q));

  p_edge_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((edge_sel & $past(edge_sel & pending & ~clr_pend) & ~pending) == '0));

  p_mask_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req & ~irq_en) == '0);

  p_req_needs_pend_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req & ~pending) == '0);
endmodule

bind strap_irq_ctrl strap_irq_ctrl_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .edge_sel(edge_sel), .irq_en(irq_en),
  .clr_pend(clr_pend), .mode_q(mode_q), .pending(pending), .irq_req(irq_req)
);

// File: tb/sim_strap_irq_ctrl.sv
module sim_strap_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pin_n = '1, edge_sel = '0, irq_en = '0, clr_pend = '0;
  logic [NP-1:0] mode_q, pending, irq_req;
  logic          wake;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  typedef struct {
    string         req;
    logic [NP-1:0] mode, pend, irq;
    logic          wk;
  } exp_t;
  exp_t sb[$];
  event sample_ev;

  strap_irq_ctrl #(.NPINS(NP), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .pin_n(pin_n), .edge_sel(edge_sel),
    .irq_en(irq_en), .clr_pend(clr_pend), .mode_q(mode_q),
    .pending(pending), .irq_req(irq_req), .wake(wake)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_now(input string req, input logic [NP-1:0] m,
                            input logic [NP-1:0] p, input logic wk);
    exp_t e;
    e.req = req; e.mode = m; e.pend = p; e.irq = p & irq_en; e.wk = |(p & irq_en);
    sb.push_back(e);
    #1 ->sample_ev;
    #1;
  endtask

  initial begin : monitor
    forever begin
      @(sample_ev);
      while (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (mode_q !== e.mode || pending !== e.pend || irq_req !== e.irq || wake !== e.wk) begin
          failures++;
          $display("FAIL %s: mode=%b pend=%b irq=%b wake=%b expected mode=%b pend=%b irq=%b wake=%b",
                   e.req, mode_q, pending, irq_req, wake, e.mode, e.pend, e.irq, e.wk);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : driver
    // Reset with edge mode, pins 0 and 3 low as strap
    edge_sel = '1; irq_en = '1; pin_n = 4'b0110;
    step(5);
    expect_now("R1 quiet in reset", 4'h0, 4'b0000, 1'b0);
    rst_n = 1'b1;
    step(1);
    expect_now("R2 strap latched", 4'h6, 4'b0000, 1'b0);
    step(4);
    expect_now("R3 strap lows no pending", 4'h6, 4'b0000, 1'b0);
    pin_n = 4'b1111;
    step(4);
    expect_now("R9 rising edge ignored", 4'h6, 4'b0000, 1'b0);
    // Falling edge on pin 0
    pin_n = 4'b1110;
    step(2);
    expect_now("R5 edge not yet visible", 4'h6, 4'b0000, 1'b0);
    step(1);
    expect_now("R5 edge pending set", 4'h6, 4'b0001, 1'b1);
    expect_now("R8 wake on request", 4'h6, 4'b0001, 1'b1);
    pin_n = 4'b1111;
    step(3);
    expect_now("R5 sticky after pin high", 4'h6, 4'b0001, 1'b1);
    irq_en = 4'b1110;
    step(1);
    expect_now("R7 masked pending kept", 4'h6, 4'b0001, 1'b0);
    clr_pend = 4'b0001;
    step(1);
    clr_pend = '0;
    expect_now("R6 clear edge pending", 4'h6, 4'b0000, 1'b0);
    // Clear collides with a new falling edge on pin 1
    irq_en = '1;
    pin_n = 4'b1101;
    step(2);
    clr_pend = 4'b0010;
    step(1);
    clr_pend = '0;
    expect_now("R6 set wins over clear", 4'h6, 4'b0010, 1'b1);
    // Level mode
    edge_sel = '0;
    step(1);
    expect_now("R4 level low pending", 4'h6, 4'b0010, 1'b1);
    clr_pend = 4'b0010;
    step(1);
    clr_pend = '0;
    expect_now("R6 clear no effect in level", 4'h6, 4'b0010, 1'b1);
    pin_n = 4'b1111;
    step(1);
    expect_now("R4 latency one edge", 4'h6, 4'b0010, 1'b1);
    step(1);
    expect_now("R4 released after two edges", 4'h6, 4'b0000, 1'b0);
    pin_n = 4'b0111;
    step(2);
    expect_now("R4 level pin3", 4'h6, 4'b1000, 1'b1);
    irq_en = 4'b0111;
    step(1);
    expect_now("R7 mask level request", 4'h6, 4'b1000, 1'b0);
    expect_now("R8 no wake when masked", 4'h6, 4'b1000, 1'b0);
    // Second reset, new strap, level mode
    irq_en = '1;
    rst_n = 1'b0; pin_n = 4'b1001;
    step(4);
    expect_now("R1 reset clears outputs", 4'h0, 4'b0000, 1'b0);
    rst_n = 1'b1;
    step(1);
    expect_now("R2 second strap latched", 4'h9, 4'b0110, 1'b1);
    pin_n = 4'b0000;
    step(5);
    expect_now("R2 mode holds after pins change", 4'h9, 4'b1111, 1'b1);
    step(1);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule